// File: doc/BRIEF.md
# Masked-Write GPIO Port Controller

This block is a memory-mapped general-purpose I/O controller that serves one or more ports of sixteen pins each. Software drives pins through two writable register arrays, one holding the output levels and one holding the pin directions, and observes the pins through a third, read-only array that reports the synchronized level of every pin.

Each write to an output or direction register carries its own bit mask. Bits 31:16 of the write word select which pins change, and bits 15:0 give their new values. A single pin can therefore be flipped with one bus write, with no read-modify-write and no race against other software that owns neighbouring pins. A direction bit of 1 makes the pin an input with its driver off. A direction bit of 0 turns the driver on. Each register kind has its own base address and one 32-bit word per port at a 4-byte stride. No interrupts are produced.

Top module: `gpio_mw_ctrl`

## Requirements
- R1: After reset every direction bit is 1, every output bit is 0, `pin_oe` is all zeros and `pin_out` is all zeros.
- R2: A write to the output register of port p sets each stored bit i, for which write bit 16+i is 1, to write bit i. Pin n of the device is bit n%16 of port n/16.
- R3: Stored output and direction bits whose mask bit is 0 keep their value, whatever the low half-word of the write holds.
- R4: A write to the direction register of port p updates the bits selected by the mask in the same way, and `pin_oe` for each pin equals the inverse of its stored direction bit from the cycle after the write.
- R5: `pin_out` always presents the stored output bit, so a pin switched to output drives its already stored level in the same cycle as its enable rises.
- R6: A read of the level register of port p returns, in bits 15:0, the state of `pin_in` for that port two clock edges earlier, whatever the pin's direction.
- R7: Port p of each kind sits at its base address plus 4*p (base offsets: output 0x00, level 0x20, direction 0x40 by default). Words that are not aligned, and words beyond the last port, are not mapped.
- R8: Reads of any register return zeros in bits 31:16. The output and direction registers read back their stored 16 bits in bits 15:0.
- R9: Writes to a level register and writes to unmapped addresses change no stored bit. Reads of unmapped addresses return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write word: mask in 31:16, values in 15:0 |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pin_out | output | 16*NUM_PORTS | Output level for each pin |
| pin_oe | output | 16*NUM_PORTS | Output driver enable for each pin, active high |
| pin_in | input | 16*NUM_PORTS | Pin levels sampled from the pads |

## Verification
A wrong stored output or direction bit shows on `pin_out` or `pin_oe` at the very next sample after the edge that stored it, and again on readback of that register. For this reason, every write in the random mix is followed at once by a full comparison of both pin vectors against a bench model. A fault in the address decode shows up as a change in some other port's pins, or as a non-zero read of a hole. A fault in the input path shows as a level read that is off by a cycle; the directed level checks sample exactly two edges after `pin_in` changes.

// File: rtl/gpio_mw_pkg.sv
package gpio_mw_pkg;
  localparam int PINS_PER_PORT = 16;

  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_DATA  = 2'd1,
    KIND_LEVEL = 2'd2,
    KIND_MODE  = 2'd3
  } reg_kind_e;

  // merge the value half into the old state, only where the mask half is set
  function automatic logic [PINS_PER_PORT-1:0] masked_merge(
    input logic [PINS_PER_PORT-1:0] old_bits,
    input logic [31:0]              wword
  );
    logic [PINS_PER_PORT-1:0] sel;
    sel = wword[31:16];
    return (old_bits & ~sel) | (wword[15:0] & sel);
  endfunction
endpackage

// File: rtl/gpio_mw_sync.sv
module gpio_mw_sync #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q;
  logic [WIDTH-1:0] stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_mw_port.sv
module gpio_mw_port
  import gpio_mw_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     data_wr,
  input  logic                     mode_wr,
  input  logic [31:0]              wword,
  input  logic [PINS_PER_PORT-1:0] pads_in,
  output logic [PINS_PER_PORT-1:0] data_q,
  output logic [PINS_PER_PORT-1:0] mode_q,
  output logic [PINS_PER_PORT-1:0] level_q
);
  logic [PINS_PER_PORT-1:0] data_d;
  logic [PINS_PER_PORT-1:0] mode_d;

  always_comb begin
    data_d = data_q;
    mode_d = mode_q;
    if (data_wr) data_d = masked_merge(data_q, wword);
    if (mode_wr) mode_d = masked_merge(mode_q, wword);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      mode_q <= '1;
    end else begin
      if (data_wr) data_q <= data_d;
      if (mode_wr) mode_q <= mode_d;
    end
  end

  gpio_mw_sync #(.WIDTH(PINS_PER_PORT)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pads_in),
    .sync_out (level_q)
  );
endmodule

// File: rtl/gpio_mw_ctrl.sv
module gpio_mw_ctrl
  import gpio_mw_pkg::*;
#(
  parameter int                NUM_PORTS  = 2,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 'h00,
  parameter logic [ADDR_W-1:0] LEVEL_BASE = 'h20,
  parameter logic [ADDR_W-1:0] MODE_BASE  = 'h40
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [ADDR_W-1:0]                  bus_addr,
  input  logic                               bus_we,
  input  logic [31:0]                        bus_wdata,
  output logic [31:0]                        bus_rdata,
  output logic [PINS_PER_PORT*NUM_PORTS-1:0] pin_out,
  output logic [PINS_PER_PORT*NUM_PORTS-1:0] pin_oe,
  input  logic [PINS_PER_PORT*NUM_PORTS-1:0] pin_in
);
  localparam int                IDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;
  localparam logic [ADDR_W-1:0] SPAN  = ADDR_W'(4 * NUM_PORTS);

  logic              hit_data, hit_level, hit_mode;
  logic [IDX_W-1:0]  idx_data, idx_level, idx_mode;
  reg_kind_e         kind;
  logic [IDX_W-1:0]  sel_idx;

  function automatic logic in_window(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base);
    return (a >= base) && ((a - base) < SPAN) && (a[1:0] == 2'b00);
  endfunction

  function automatic logic [IDX_W-1:0] word_index(input logic [ADDR_W-1:0] a,
                                                   input logic [ADDR_W-1:0] base);
    logic [ADDR_W-1:0] off;
    off = (a - base) >> 2;
    return IDX_W'(off);
  endfunction

  always_comb begin
    hit_data  = in_window(bus_addr, DATA_BASE);
    hit_level = in_window(bus_addr, LEVEL_BASE);
    hit_mode  = in_window(bus_addr, MODE_BASE);
    idx_data  = word_index(bus_addr, DATA_BASE);
    idx_level = word_index(bus_addr, LEVEL_BASE);
    idx_mode  = word_index(bus_addr, MODE_BASE);
    kind      = KIND_NONE;
    sel_idx   = '0;
    if (hit_data) begin
      kind    = KIND_DATA;
      sel_idx = idx_data;
    end else if (hit_level) begin
      kind    = KIND_LEVEL;
      sel_idx = idx_level;
    end else if (hit_mode) begin
      kind    = KIND_MODE;
      sel_idx = idx_mode;
    end
  end

  logic [PINS_PER_PORT-1:0] data_arr  [NUM_PORTS];
  logic [PINS_PER_PORT-1:0] mode_arr  [NUM_PORTS];
  logic [PINS_PER_PORT-1:0] level_arr [NUM_PORTS];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic data_wr, mode_wr;
    assign data_wr = bus_we && (kind == KIND_DATA) && (sel_idx == IDX_W'(p));
    assign mode_wr = bus_we && (kind == KIND_MODE) && (sel_idx == IDX_W'(p));

    gpio_mw_port u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .data_wr (data_wr),
      .mode_wr (mode_wr),
      .wword   (bus_wdata),
      .pads_in (pin_in[p*PINS_PER_PORT +: PINS_PER_PORT]),
      .data_q  (data_arr[p]),
      .mode_q  (mode_arr[p]),
      .level_q (level_arr[p])
    );

    assign pin_out[p*PINS_PER_PORT +: PINS_PER_PORT] = data_arr[p];
    assign pin_oe [p*PINS_PER_PORT +: PINS_PER_PORT] = ~mode_arr[p];
  end

  always_comb begin
    bus_rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (sel_idx == IDX_W'(p)) begin
        unique case (kind)
          KIND_DATA:  bus_rdata[15:0] = data_arr[p];
          KIND_LEVEL: bus_rdata[15:0] = level_arr[p];
          KIND_MODE:  bus_rdata[15:0] = mode_arr[p];
          default:    bus_rdata[15:0] = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_mw_chk.sv
module gpio_mw_chk #(
  parameter int                NUM_PORTS  = 2,
  parameter int                ADDR_W     = 8,
  parameter logic [ADDR_W-1:0] LEVEL_BASE = 'h20
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic                      bus_we,
  input logic [31:0]               bus_rdata,
  input logic [16*NUM_PORTS-1:0]   pin_out,
  input logic [16*NUM_PORTS-1:0]   pin_oe,
  input logic [16*NUM_PORTS-1:0]   pin_in
);
  logic [1:0] edges_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              edges_q <= 2'd0;
    else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
  end

  // R3: with no write strobe, no stored pin state may move
  a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we |=> ($stable(pin_out) && $stable(pin_oe)));

  // R5: one write touches only one register kind, so level and enable never move together
  a_r5_no_glitch: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pin_oe) |-> $stable(pin_out));

  // R8: upper half of every read is zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:16] == 16'h0000);

  // R9: a write aimed at the level word of port 0 leaves the pins alone
  a_r9_level_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == LEVEL_BASE) |=> ($stable(pin_out) && $stable(pin_oe)));

  // R6: level read of port 0 shows the pads two edges back
  a_r6_level_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (edges_q >= 2'd2 && bus_addr == LEVEL_BASE) |-> bus_rdata[15:0] == $past(pin_in[15:0], 2));
endmodule

bind gpio_mw_ctrl gpio_mw_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .ADDR_W     (ADDR_W),
  .LEVEL_BASE (LEVEL_BASE)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .pin_in    (pin_in)
);

// File: tb/gpio_mw_ctrl_tb.sv
module gpio_mw_ctrl_tb;
  localparam int NP = 2;
  localparam int NB = 16 * NP;

  logic          clk;
  logic          rst_n;
  logic [7:0]    bus_addr;
  logic          bus_we;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [NB-1:0] pin_out;
  logic [NB-1:0] pin_oe;
  logic [NB-1:0] pin_in;

  int checks = 0;
  int failures = 0;
  logic [15:0] m_data [NP];
  logic [15:0] m_mode [NP];

  gpio_mw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_out(pin_out),
    .pin_oe(pin_oe), .pin_in(pin_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [15:0] f_merge(input logic [15:0] old, input logic [31:0] w);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = w[16+i] ? w[i] : old[i];
    return r;
  endfunction

  function automatic logic [NB-1:0] f_out();
    logic [NB-1:0] v;
    for (int p = 0; p < NP; p++) v[p*16 +: 16] = m_data[p];
    return v;
  endfunction

  function automatic logic [NB-1:0] f_oe();
    logic [NB-1:0] v;
    for (int p = 0; p < NP; p++) v[p*16 +: 16] = ~m_mode[p];
    return v;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    bus_we = 1'b0;
    bus_addr = a;
    #1;
    check(req, 64'(bus_rdata), 64'(exp));
  endtask

  task automatic pins(input string req);
    check(req, 64'(pin_out), 64'(f_out()));
    check(req, 64'(pin_oe), 64'(f_oe()));
  endtask

  initial begin
    #200000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'd1357;
    void'($urandom(seed));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; pin_in = '0;
    for (int p = 0; p < NP; p++) begin m_data[p] = 16'h0000; m_mode[p] = 16'hFFFF; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 out", 64'(pin_out), 64'(0));
    check("R1 oe", 64'(pin_oe), 64'(0));
    rd(8'h40, 32'h0000FFFF, "R1 mode");
    rd(8'h44, 32'h0000FFFF, "R1 mode p1");

    // R2 single pin set, pin 17 = port 1 bit 1
    wr(8'h04, 32'h0002_0002); m_data[1] = 16'h0002;
    check("R2 pin17", 64'(pin_out[17]), 64'(1));
    pins("R2");
    // R3 unmasked bits ignore data half
    wr(8'h04, 32'h0001_FFFC); m_data[1] = 16'h0002;
    pins("R3 data");
    rd(8'h04, 32'h0000_0002, "R3 readback");

    // R5 store level first, then switch to output
    wr(8'h00, 32'h0080_0080); m_data[0] = 16'h0080;
    wr(8'h40, 32'h0080_0000); m_mode[0] = 16'hFF7F;
    check("R5 drive", 64'({pin_oe[7], pin_out[7]}), 64'(2'b11));
    // R4 mode masked, oe inverse
    wr(8'h40, 32'h0100_FFFF); m_mode[0] = 16'hFF7F;
    pins("R4 mode mask");
    rd(8'h40, 32'h0000_FF7F, "R4 R8 readback");

    // R9 writes to level and holes
    wr(8'h20, 32'hFFFF_0000); pins("R9 level write");
    wr(8'h08, 32'hFFFF_FFFF); pins("R9 past last port");
    wr(8'h01, 32'hFFFF_FFFF); pins("R9 unaligned");
    wr(8'h60, 32'hFFFF_0000); pins("R9 hole");
    rd(8'h08, 32'h0, "R7 R9 read past last port");
    rd(8'h4C, 32'h0, "R7 R9 read mode hole");

    // R6 level latency, pin driven as output but read level still from pads
    @(negedge clk); pin_in = 32'hA5A5_3C3C;
    @(negedge clk); rd(8'h20, 32'h0, "R6 one edge");
    @(negedge clk); rd(8'h20, 32'h0000_3C3C, "R6 two edges");
    rd(8'h24, 32'h0000_A5A5, "R6 R7 port1");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int p;
      int k;
      logic [31:0] w;
      p = int'($urandom_range(NP - 1));
      k = int'($urandom_range(3));
      w = $urandom;
      case (k)
        0: begin wr(8'(p*4), w); m_data[p] = f_merge(m_data[p], w); pins("R2 R3 rand");
                  rd(8'(p*4), {16'h0, m_data[p]}, "R8 rand data"); end
        1: begin wr(8'(8'h40 + p*4), w); m_mode[p] = f_merge(m_mode[p], w); pins("R4 rand");
                  rd(8'(8'h40 + p*4), {16'h0, m_mode[p]}, "R8 rand mode"); end
        2: begin @(negedge clk); pin_in = {$urandom, $urandom};
                  repeat (2) @(negedge clk);
                  rd(8'(8'h20 + p*4), {16'h0, pin_in[p*16 +: 16]}, "R6 rand"); end
        default: begin wr(8'(8'h20 + p*4), w); pins("R9 rand"); end
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule